// File: doc/BRIEF.md
# Core Clock Divider with Nap-Gated Source Switch

This block derives the processor core clock from the PLL output clock. A free-running ripple-free binary counter runs on the PLL clock, and a divider code selects one of its bits, or the PLL clock itself, as the core clock, giving a division by two to the power of the code. A new code is taken up only when every counter bit is about to fall together, so the core clock never carries a shortened high or low phase.

The block also sequences a change of the PLL reference between the internal oscillator and an external crystal. Software writes a request into the clock-control register. The request is held pending and committed to the `active_src` output only on the cycle the block leaves nap because of the wake interrupt. While napping, the core clock is held low. On wake it restarts from a cleared counter. Software must program the wake timer to more than 120 µs before requesting nap, so that the reference has settled before the core runs again. Both control registers sit behind a key: a write carrying the key value must be followed, on the very next bus access, by the data write.

Top module: `coreclk_ctrl`

## Requirements
- R1: After reset the divider code is 3, so the core clock runs at one eighth of the PLL clock, and `active_src` is 0, which selects the internal oscillator.
- R2: For a divider code N from 1 to 7, `core_clk` is a 50 % duty clock with a period of 2^N PLL cycles. For code 0, `core_clk` follows `pll_clk`.
- R3: A newly written divider code comes into force only on the PLL edge where the counter wraps from all ones to zero, or while napping. No high or low phase of `core_clk` is ever shorter than the old or the new setting would give.
- R4: A register write takes effect only if the access immediately before it, with no other bus access in between, wrote the key value 0xA5 to address 0. Any other access, including a wrong key, discards the armed state. An unarmed data write changes nothing.
- R5: Clock-control register (address 1). Bit 2 set requests the internal oscillator. Bit 2 clear with bits [1:0] equal to 01 requests the external crystal. Any other value leaves the pending request unchanged.
- R6: `active_src` changes only on the PLL edge at which the block leaves nap. It then takes the pending request.
- R7: A `nap_req` pulse while awake enters nap, and `core_clk` is low from that edge on. A `wake_irq` pulse while napping leaves nap, and the counter restarts from zero with the pending divider code.
- R8: Power-control register (address 2). Bits [2:0] hold the divider code.
- R9: `nap_req` while already napping, and `wake_irq` while awake, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | PLL output clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | One-cycle register write strobe |
| bus_addr | input | 2 | 0 = key, 1 = clock control, 2 = power control |
| bus_wdata | input | 8 | Write data |
| nap_req | input | 1 | Request to enter nap |
| wake_irq | input | 1 | Wake timer interrupt, which ends nap |
| core_clk | output | 1 | Divided core clock |
| active_src | output | 1 | Committed PLL reference: 0 = internal oscillator, 1 = external crystal |

## Verification
The bench uses the default parameters: a 3-bit code, so divisions from 1 to 128, 8-bit data and key 0xA5. With these the slowest wrap boundary is only 128 cycles away, so random code writes regularly land on every counter phase, mid-period and at the wrap. Random nap and wake pulses then interleave with pending source requests and with keys that are interrupted. Directed sequences measure the period of `core_clk` at the ports after reset, after a protected write, after a discarded write and with the code-0 bypass.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam logic [1:0] ADDR_KEY = 2'd0;
  localparam logic [1:0] ADDR_CLK = 2'd1;
  localparam logic [1:0] ADDR_PWR = 2'd2;
  localparam logic [1:0] MODE_XTAL = 2'b01;
  localparam int OSEL_BIT = 2;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_sn = stg_q[1];
endmodule

// File: rtl/ccs_key_gate.sv
module ccs_key_gate #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_VAL = 'hA5
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              clk_we,
  output logic              pwr_we
);
  import ccs_pkg::*;

  logic armed_q;
  logic armed_d;
  logic key_hit;

  always_comb begin
    key_hit = (bus_addr == ADDR_KEY) && (bus_wdata == KEY_VAL);
    armed_d = armed_q;
    if (bus_wr) armed_d = key_hit;
    clk_we = bus_wr && armed_q && (bus_addr == ADDR_CLK);
    pwr_we = bus_wr && armed_q && (bus_addr == ADDR_PWR);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  AST_KEY_SINGLE_USE: assert property (@(posedge clk) disable iff (!rst_sn)
    (clk_we || pwr_we) |=> !armed_q); // R4
  AST_KEY_NO_STALE: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && (bus_addr != ADDR_KEY)) |=> !armed_q); // R4
endmodule

// File: rtl/ccs_div.sv
module ccs_div #(
  parameter int CODE_W = 3,
  parameter int RST_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              hold,
  input  logic [CODE_W-1:0] code_req,
  output logic              core_clk
);
  localparam int TAP_N = 1 << CODE_W;
  localparam int CNT_W = TAP_N - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [TAP_N-1:0]  taps;
  logic              wrap;

  always_comb begin
    wrap   = (cnt_q == '1);
    cnt_d  = hold ? '0 : cnt_q + CNT_W'(1);
    code_d = (hold || wrap) ? code_req : code_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      code_q <= CODE_W'(RST_CODE);
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  assign taps     = {cnt_q, clk};
  assign core_clk = !hold && taps[code_q];

  AST_CODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_sn)
    (code_q != $past(code_q)) |-> ($past(hold) || (cnt_q == '0))); // R3
  AST_NAP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_sn)
    hold |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/coreclk_ctrl.sv
module coreclk_ctrl #(
  parameter int CODE_W = 3,
  parameter int DATA_W = 8,
  parameter int RST_CODE = 3,
  parameter logic [DATA_W-1:0] KEY_VAL = 'hA5
) (
  input  logic              pll_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              nap_req,
  input  logic              wake_irq,
  output logic              core_clk,
  output logic              active_src
);
  import ccs_pkg::*;

  logic rst_sn;
  logic clk_we, pwr_we;
  src_e src_q, src_d, pend_q, pend_d;
  logic nap_q, nap_d;
  logic [CODE_W-1:0] code_q, code_d;

  ccs_rst_sync u_rst (
    .clk(pll_clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  ccs_key_gate #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_key (
    .clk(pll_clk), .rst_sn(rst_sn), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .clk_we(clk_we), .pwr_we(pwr_we)
  );

  always_comb begin
    pend_d = pend_q;
    if (clk_we) begin
      if (bus_wdata[OSEL_BIT])              pend_d = SRC_INT;
      else if (bus_wdata[1:0] == MODE_XTAL) pend_d = SRC_EXT;
    end
    code_d = pwr_we ? bus_wdata[CODE_W-1:0] : code_q;
    nap_d = nap_q;
    src_d = src_q;
    if (!nap_q && nap_req) begin
      nap_d = 1'b1;
    end else if (nap_q && wake_irq) begin
      nap_d = 1'b0;
      src_d = pend_q;
    end
  end

  always_ff @(posedge pll_clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_q <= SRC_INT;
      src_q  <= SRC_INT;
      nap_q  <= 1'b0;
      code_q <= CODE_W'(RST_CODE);
    end else begin
      pend_q <= pend_d;
      src_q  <= src_d;
      nap_q  <= nap_d;
      code_q <= code_d;
    end
  end

  ccs_div #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_div (
    .clk(pll_clk), .rst_sn(rst_sn), .hold(nap_q), .code_req(code_q),
    .core_clk(core_clk)
  );

  assign active_src = src_q;

  AST_SRC_ONLY_ON_WAKE: assert property (@(posedge pll_clk) disable iff (!rst_sn)
    (nap_q || !$past(nap_q)) |-> $stable(src_q)); // R6
  AST_WAKE_COMMITS_PENDING: assert property (@(posedge pll_clk) disable iff (!rst_sn)
    ($past(nap_q) && !nap_q) |-> (src_q == $past(pend_q))); // R7
  AST_NAP_OUTPUT_LOW: assert property (@(posedge pll_clk) disable iff (!rst_sn)
    ($past(nap_q) && nap_q) |-> (core_clk == 1'b0)); // R7
endmodule

// File: tb/coreclk_ctrl_test.sv
`timescale 1ns/1ps
module coreclk_ctrl_test;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic nap_req, wake_irq;
  logic core_clk, active_src;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coreclk_ctrl uut (
    .pll_clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .nap_req(nap_req), .wake_irq(wake_irq),
    .core_clk(core_clk), .active_src(active_src)
  );

  // Reference model built from the requirements
  logic [1:0] m_rs;
  logic [6:0] m_cnt;
  logic [2:0] m_code, m_pcode;
  logic m_src, m_psrc, m_nap, m_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00; m_cnt <= '0; m_code <= 3'd3; m_pcode <= 3'd3;
      m_src <= 1'b0; m_psrc <= 1'b0; m_nap <= 1'b0; m_armed <= 1'b0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (m_rs[1]) begin
        if (bus_wr) m_armed <= (bus_addr == 2'd0) && (bus_wdata == KEY);
        if (bus_wr && m_armed && bus_addr == 2'd1) begin
          if (bus_wdata[2]) m_psrc <= 1'b0;
          else if (bus_wdata[1:0] == 2'b01) m_psrc <= 1'b1;
        end
        if (bus_wr && m_armed && bus_addr == 2'd2) m_pcode <= bus_wdata[2:0];
        if (!m_nap && nap_req) m_nap <= 1'b1;
        else if (m_nap && wake_irq) begin m_nap <= 1'b0; m_src <= m_psrc; end
        if (m_nap) begin m_cnt <= '0; m_code <= m_pcode; end
        else begin
          m_cnt <= m_cnt + 7'd1;
          if (m_cnt == 7'h7f) m_code <= m_pcode;
        end
      end
    end
  end

  function automatic logic exp_clk(input logic phase);
    if (m_nap) return 1'b0;
    if (m_code == 3'd0) return phase;
    return m_cnt[m_code - 3'd1];
  endfunction

  task automatic check_port(input logic phase);
    logic e;
    e = exp_clk(phase);
    tests++;
    if (core_clk !== e) begin
      fails++;
      $display("FAIL R2/R3/R7 core_clk at %0t: actual %0b expected %0b", $time, core_clk, e);
    end
    tests++;
    if (active_src !== m_src) begin
      fails++;
      $display("FAIL R6 active_src at %0t: actual %0b expected %0b", $time, active_src, m_src);
    end
  endtask

  always @(negedge clk) begin #1 if (!done) check_port(1'b0); end
  always @(posedge clk) begin #2 if (!done) check_port(1'b1); end

  task automatic summary;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      tests++; fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic bus(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic prot(input logic [1:0] a, input logic [7:0] d);
    bus(2'd0, KEY);
    bus(a, d);
  endtask

  task automatic pulse_nap;
    @(negedge clk); #1 nap_req = 1'b1;
    @(negedge clk); #1 nap_req = 1'b0;
  endtask

  task automatic pulse_wake;
    @(negedge clk); #1 wake_irq = 1'b1;
    @(negedge clk); #1 wake_irq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic period_is(input int exp, input string tag);
    realtime t1;
    int per;
    @(posedge core_clk); t1 = $realtime;
    @(posedge core_clk);
    per = int'(($realtime - t1) / 10.0);
    tests++;
    if (per != exp) begin
      fails++;
      $display("FAIL %s core_clk period: actual %0d expected %0d", tag, per, exp);
    end
  endtask

  task automatic src_is(input logic exp, input string tag);
    @(negedge clk); #1;
    tests++;
    if (active_src !== exp) begin
      fails++;
      $display("FAIL %s active_src: actual %0b expected %0b", tag, active_src, exp);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    nap_req = 1'b0; wake_irq = 1'b0;
    idle(4);
    #1 rst_n = 1'b1;
    // R1: reset state
    src_is(1'b0, "R1");
    period_is(8, "R1");
    // R8: protected write of code 1
    prot(2'd2, 8'h01);
    idle(300);
    period_is(2, "R8");
    // R4: key broken by an intervening access, then wrong key
    bus(2'd0, KEY); bus(2'd0, 8'h5A); bus(2'd2, 8'h05);
    bus(2'd0, KEY); bus(2'd1, 8'h06); bus(2'd2, 8'h05);
    bus(2'd2, 8'h04);
    idle(300);
    period_is(2, "R4");
    // R2: code 0 bypass
    prot(2'd2, 8'h00);
    idle(300);
    period_is(1, "R2");
    // R5: mode 10 does not request the crystal; R9: wake while awake ignored
    prot(2'd1, 8'h02);
    pulse_wake();
    pulse_nap(); idle(5); pulse_wake();
    src_is(1'b0, "R5");
    // R6: crystal request stays pending until wake
    prot(2'd1, 8'h01);
    idle(20);
    src_is(1'b0, "R6");
    pulse_nap(); idle(3); pulse_nap(); idle(10);
    src_is(1'b0, "R9");
    prot(2'd2, 8'h02);
    pulse_wake();
    src_is(1'b1, "R7");
    period_is(4, "R7");
    // back to internal via osel bit
    prot(2'd1, 8'h07);
    pulse_nap(); idle(8); pulse_wake();
    src_is(1'b0, "R5");
    // R3 and the rest: random mix checked by the model every half cycle
    for (int k = 0; k < 2500; k++) begin
      int r;
      r = int'($urandom % 16);
      case (r)
        0, 1: prot(2'd2, 8'($urandom % 8));
        2:    prot(2'd1, 8'($urandom % 8));
        3:    bus(2'($urandom % 4), 8'($urandom));
        4:    pulse_nap();
        5:    pulse_wake();
        6:    begin bus(2'd0, KEY); bus(2'($urandom % 4), 8'($urandom % 8)); end
        default: idle(int'($urandom % 6) + 1);
      endcase
    end
    idle(10);
    summary();
  end
endmodule